// File: doc/BRIEF.md
# I2C Command-Register Target

This block is an I2C target that sits in front of a small register space. A host addresses it with a 7-bit device address. The first byte after a write-direction address is a command byte, and it sets an internal 8-bit location pointer. Every following data byte is either written to the location under the pointer or, after a repeated start and a read-direction address, read from it. The pointer steps forward by one after each acknowledged data byte. As a result, a single packet can write or read a run of consecutive locations.

The target turns away bad traffic on the bus. It does not acknowledge a foreign address, a command byte above the highest valid location, or a data byte aimed at a read-only location. A watchdog covers a bus that stays low. Once either line has been low without a break for a programmable number of clock cycles, the target lets go of both lines. If a line is still low a short settle time after that, something outside is holding it, and the target raises a sleep request.

The pins are open-drain. The block takes the raw line levels in and returns drive-low enables. The register file is outside the block and is reached through a combinational read port and a one-cycle write strobe.

Top module: `i2cCmdTarget`

## Requirements
- R1: After a start, the target acknowledges an address byte (sent MSB first, with the direction bit last, 1 meaning read) whose upper seven bits equal DEV_ADDR. It pulls SDA low for the whole acknowledge clock.
- R2: A command byte of at most MAX_CMD (default 0x6B) is acknowledged and loads the pointer, which appears on regAddr.
- R3: A command byte above MAX_CMD is not acknowledged and leaves the pointer unchanged.
- R4: A data byte written to a location whose regReadOnly is 0 is acknowledged. It produces exactly one single-cycle regWrEn pulse, with regAddr equal to the pointer and regWrData equal to the byte. Afterwards the pointer advances by one.
- R5: A data byte written to a location whose regReadOnly is 1 is not acknowledged. It causes no regWrEn, and the pointer stays put.
- R6: In a read, bytes go out MSB first from the pointer location, and SDA changes only while SCL is low. The pointer advances after each byte the host acknowledges and not after the byte it refuses. After a refused byte the target stops driving.
- R7: After an address that does not match, the target drives nothing and writes nothing until the next start.
- R8: A start or stop at any point abandons the current byte and returns to address matching. The pointer keeps its value.
- R9: When SCL or SDA has been low without a break for STUCK_CYCLES clock cycles, both drive-low enables are 0.
- R10: sleepReq is 1 when a line is still low SETTLE_CYCLES after that release. It returns to 0 once both lines are high.
- R11: Out of reset no line is driven, regWrEn is 0 and sleepReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDriveLow | output | 1 | SCL pull-down enable (never set: no clock stretching) |
| sdaDriveLow | output | 1 | SDA pull-down enable |
| regAddr | output | 8 | Current location pointer |
| regWrData | output | 8 | Byte to store |
| regWrEn | output | 1 | One-cycle store strobe |
| regRdData | input | 8 | Contents of location regAddr |
| regReadOnly | input | 1 | Location regAddr refuses writes |
| sleepReq | output | 1 | A line stays low after the watchdog released the bus |

## Verification
The assertions assume that regReadOnly and regRdData depend only on regAddr and settle within the same cycle. They also assume SCL stays high or low for several clock cycles at a time, so that a target drive change is seen a few cycles after an SCL fall. The bench models the register file as a combinational lookup on regAddr, and it holds each quarter of an SCL period for 25 system cycles. The watchdog limit is shortened, but it stays well above the longest low stretch that a legal byte of zeros can create.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  localparam int BYTE_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int BIT_CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_MACK,
    ST_SKIP
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic shiftIn;
    logic shiftTx;
    logic loadTx;
    logic loadPtr;
    logic incPtr;
    logic wrStb;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic              sclRise;
    logic              sclFall;
    logic              start;
    logic              stop;
    logic              sdaS;
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
    logic              rdMsb;
    logic              txNext;
    logic              released;
  } dpStat_t;

endpackage

// File: rtl/i2cTgtWatchdog.sv
module i2cTgtWatchdog #(
  parameter int STUCK_CYCLES  = 100_000_000,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclS,
  input  logic sdaS,
  output logic released,
  output logic sleepReq
);

  localparam int CNT_MAX = STUCK_CYCLES + SETTLE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (sclS && sdaS) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_W'(CNT_MAX)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign released = (lowCnt >= CNT_W'(STUCK_CYCLES));
  assign sleepReq = (lowCnt >= CNT_W'(CNT_MAX));

endmodule

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int STUCK_CYCLES  = 100_000_000,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtrl_t           ctrl,
  input  logic [BYTE_W-1:0] regRdData,
  output dpStat_t           stat,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              sleepReq
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sclS;
  logic                   sdaS;
  logic [BYTE_W-1:0]      rxShift;
  logic [BYTE_W-1:0]      txShift;
  logic [BIT_CNT_W-1:0]   bitCnt;
  logic [BYTE_W-1:0]      ptr;
  logic                   released;

  // two-flop synchronizers, reset to the idle (high) bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // receive shifter and bit counter (also counts transmitted bits)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (ctrl.clrBits) begin
      bitCnt <= '0;
    end else if (ctrl.shiftIn) begin
      rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (ctrl.loadTx) begin
      txShift <= regRdData;
    end else if (ctrl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // location pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctrl.loadPtr) begin
      ptr <= rxShift;
    end else if (ctrl.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  // register-file write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= ctrl.wrStb;
      if (ctrl.wrStb) begin
        regWrData <= rxShift;
      end
    end
  end

  i2cTgtWatchdog #(
    .STUCK_CYCLES (STUCK_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_watchdog (
    .clk     (clk),
    .rstN    (rstN),
    .sclS    (sclS),
    .sdaS    (sdaS),
    .released(released),
    .sleepReq(sleepReq)
  );

  assign regAddr = ptr;

  always_comb begin
    stat          = '0;
    stat.sclRise  = sclS & ~sclPrev;
    stat.sclFall  = ~sclS & sclPrev;
    stat.start    = sclS & sclPrev & sdaPrev & ~sdaS;
    stat.stop     = sclS & sclPrev & ~sdaPrev & sdaS;
    stat.sdaS     = sdaS;
    stat.byteDone = (bitCnt == BIT_CNT_W'(BYTE_W));
    stat.rxByte   = rxShift;
    stat.rdMsb    = regRdData[BYTE_W-1];
    stat.txNext   = txShift[BYTE_W-2];
    stat.released = released;
  end

endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter logic [6:0]        DEV_ADDR = 7'h55,
  parameter logic [BYTE_W-1:0] MAX_CMD  = 8'h6B
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    regReadOnly,
  output dpCtrl_t ctrl,
  output logic    sdaLow
);

  tgtState_e state, nextState;
  logic      sdaLowQ, nextSda;
  logic      isReadQ, nextIsRead;
  logic      mAckQ, nextMAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sdaLowQ <= 1'b0;
      isReadQ <= 1'b0;
      mAckQ   <= 1'b0;
    end else begin
      state   <= nextState;
      sdaLowQ <= nextSda;
      isReadQ <= nextIsRead;
      mAckQ   <= nextMAck;
    end
  end

  always_comb begin
    nextState  = state;
    nextSda    = sdaLowQ;
    nextIsRead = isReadQ;
    nextMAck   = mAckQ;
    ctrl       = '0;

    if (stat.released) begin
      nextState = ST_IDLE;
      nextSda   = 1'b0;
    end else if (stat.start) begin
      nextState    = ST_ADDR;
      nextSda      = 1'b0;
      ctrl.clrBits = 1'b1;
    end else if (stat.stop) begin
      nextState = ST_IDLE;
      nextSda   = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (stat.sclRise) begin
            ctrl.shiftIn = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            if (stat.rxByte[BYTE_W-1:1] == DEV_ADDR) begin
              nextState  = ST_ADDR_ACK;
              nextSda    = 1'b1;
              nextIsRead = stat.rxByte[0];
            end else begin
              nextState = ST_SKIP;
            end
          end
        end

        ST_ADDR_ACK: begin
          if (stat.sclFall) begin
            ctrl.clrBits = 1'b1;
            if (isReadQ) begin
              ctrl.loadTx = 1'b1;
              nextSda     = ~stat.rdMsb;
              nextState   = ST_RDATA;
            end else begin
              nextSda   = 1'b0;
              nextState = ST_CMD;
            end
          end
        end

        ST_CMD: begin
          if (stat.sclRise) begin
            ctrl.shiftIn = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            if (stat.rxByte <= MAX_CMD) begin
              ctrl.loadPtr = 1'b1;
              nextSda      = 1'b1;
              nextState    = ST_CMD_ACK;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end

        ST_CMD_ACK: begin
          if (stat.sclFall) begin
            ctrl.clrBits = 1'b1;
            nextSda      = 1'b0;
            nextState    = ST_WDATA;
          end
        end

        ST_WDATA: begin
          if (stat.sclRise) begin
            ctrl.shiftIn = 1'b1;
          end else if (stat.sclFall && stat.byteDone) begin
            if (!regReadOnly) begin
              ctrl.wrStb = 1'b1;
              nextSda    = 1'b1;
              nextState  = ST_WDATA_ACK;
            end else begin
              nextState = ST_SKIP;
            end
          end
        end

        ST_WDATA_ACK: begin
          if (stat.sclFall) begin
            ctrl.incPtr  = 1'b1;
            ctrl.clrBits = 1'b1;
            nextSda      = 1'b0;
            nextState    = ST_WDATA;
          end
        end

        ST_RDATA: begin
          if (stat.sclRise) begin
            ctrl.shiftIn = 1'b1;
          end else if (stat.sclFall) begin
            if (stat.byteDone) begin
              nextSda   = 1'b0;
              nextState = ST_RDATA_MACK;
            end else begin
              ctrl.shiftTx = 1'b1;
              nextSda      = ~stat.txNext;
            end
          end
        end

        ST_RDATA_MACK: begin
          if (stat.sclRise) begin
            nextMAck    = ~stat.sdaS;
            ctrl.incPtr = ~stat.sdaS;
          end else if (stat.sclFall) begin
            if (mAckQ) begin
              ctrl.loadTx  = 1'b1;
              ctrl.clrBits = 1'b1;
              nextSda      = ~stat.rdMsb;
              nextState    = ST_RDATA;
            end else begin
              nextSda   = 1'b0;
              nextState = ST_SKIP;
            end
          end
        end

        default: begin
          nextSda = 1'b0;
        end
      endcase
    end
  end

  assign sdaLow = sdaLowQ;

endmodule

// File: rtl/i2cCmdTarget.sv
module i2cCmdTarget
  import i2cTgtPkg::*;
#(
  parameter logic [6:0]        DEV_ADDR      = 7'h55,
  parameter logic [BYTE_W-1:0] MAX_CMD       = 8'h6B,
  parameter int                STUCK_CYCLES  = 100_000_000,
  parameter int                SETTLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic              regReadOnly,
  output logic              sleepReq
);

  dpCtrl_t ctrl;
  dpStat_t stat;
  logic    sdaLow;

  i2cTgtDatapath #(
    .STUCK_CYCLES (STUCK_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ctrl     (ctrl),
    .regRdData(regRdData),
    .stat     (stat),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .sleepReq (sleepReq)
  );

  i2cTgtControl #(
    .DEV_ADDR(DEV_ADDR),
    .MAX_CMD (MAX_CMD)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .regReadOnly(regReadOnly),
    .ctrl       (ctrl),
    .sdaLow     (sdaLow)
  );

  assign sdaDriveLow = sdaLow & ~stat.released;
  assign sclDriveLow = 1'b0;

endmodule

// File: rtl/i2cCmdTargetChk.sv
module i2cCmdTargetChk #(
  parameter int STUCK_CYCLES = 100_000_000
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic regWrEn,
  input logic regReadOnly,
  input logic sleepReq
);

  localparam int LIM   = STUCK_CYCLES + 4;
  localparam int CNT_W = $clog2(LIM + 2);

  logic [CNT_W-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (sclIn && sdaIn) begin
      lowCnt <= '0;
    end else if (lowCnt <= CNT_W'(LIM)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn); // R4

  AST_WR_NOT_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !regReadOnly); // R5

  AST_SDA_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> $past(!sclIn, 2)); // R6

  AST_STUCK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt > CNT_W'(LIM)) |-> (!sdaDriveLow && !sclDriveLow)); // R9

  AST_SLEEP_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> $past(!(sclIn && sdaIn), 3)); // R10

endmodule

bind i2cCmdTarget i2cCmdTargetChk #(
  .STUCK_CYCLES(STUCK_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaIn      (sdaIn),
  .sclDriveLow(sclDriveLow),
  .sdaDriveLow(sdaDriveLow),
  .regWrEn    (regWrEn),
  .regReadOnly(regReadOnly),
  .sleepReq   (sleepReq)
);

// File: tb/i2cCmdTarget_tb.sv
module i2cCmdTarget_tb;

  localparam int          Q       = 25;
  localparam int          STUCK   = 3000;
  localparam int          SETTLE  = 16;
  localparam logic [6:0]  DEVA    = 7'h55;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mSclLow = 1'b0;
  logic       mSdaLow = 1'b0;
  logic       extSclLow = 1'b0;
  logic       sclDriveLow, sdaDriveLow, regWrEn, regReadOnly, sleepReq;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       sclLine, sdaLine;
  logic [7:0] mem [256];
  int         checks = 0;
  int         errors = 0;
  int         wrCount = 0;
  int         drvCount = 0;
  int         sleepCount = 0;

  always #10 clk = ~clk;

  assign sclLine = !(mSclLow | extSclLow | sclDriveLow);
  assign sdaLine = !(mSdaLow | sdaDriveLow);
  assign regRdData   = mem[regAddr];
  assign regReadOnly = (regAddr < 8'h10);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end

  always @(posedge clk) begin
    if (regWrEn) wrCount <= wrCount + 1;
    if (sdaDriveLow) drvCount <= drvCount + 1;
    if (sleepReq) sleepCount <= sleepCount + 1;
  end

  i2cCmdTarget #(
    .DEV_ADDR     (DEVA),
    .MAX_CMD      (8'h6B),
    .STUCK_CYCLES (STUCK),
    .SETTLE_CYCLES(SETTLE)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclLine),
    .sdaIn      (sdaLine),
    .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .regRdData  (regRdData),
    .regReadOnly(regReadOnly),
    .sleepReq   (sleepReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL clock with SCL low on entry and exit
  task automatic bitCell(input logic drv, output logic seen);
    mSdaLow = !drv; waitC(Q);
    mSclLow = 1'b0; waitC(Q);
    seen = sdaLine; waitC(Q);
    mSclLow = 1'b1; waitC(Q);
  endtask

  task automatic busStart();
    mSdaLow = 1'b0; waitC(Q);
    mSclLow = 1'b0; waitC(Q);
    mSdaLow = 1'b1; waitC(Q);
    mSclLow = 1'b1; waitC(Q);
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; waitC(Q);
    mSclLow = 1'b0; waitC(Q);
    mSdaLow = 1'b0; waitC(4 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitCell(b[i], s);
    bitCell(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitCell(1'b1, s);
      b[i] = s;
    end
    bitCell(!ackIt, s);
  endtask

  task automatic tReset();
    chk("R11 sda drive", sdaDriveLow, 0);
    chk("R11 scl drive", sclDriveLow, 0);
    chk("R11 write strobe", regWrEn, 0);
    chk("R11 sleep", sleepReq, 0);
  endtask

  task automatic tWriteRun();
    logic a0, a1, a2, a3;
    int w0 = wrCount;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h20, a1);
    sendByte(8'h3C, a2);
    sendByte(8'h00, a3);
    busStop();
    chk("R1 address ack", a0, 1);
    chk("R2 command ack", a1, 1);
    chk("R4 data acks", {a2, a3}, 2'b11);
    chk("R4 stored 0x20", mem[8'h20], 8'h3C);
    chk("R4 stored 0x21", mem[8'h21], 8'h00);
    chk("R4 strobe count", wrCount - w0, 2);
    chk("R4 pointer advanced", regAddr, 8'h22);
  endtask

  task automatic tReadRun();
    logic a0, a1, a2;
    logic [7:0] d0, d1, d2;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h20, a1);
    busStart();
    sendByte({DEVA, 1'b1}, a2);
    recvByte(d0, 1'b1);
    recvByte(d1, 1'b1);
    recvByte(d2, 1'b0);
    busStop();
    chk("R1 read address ack", a2, 1);
    chk("R6 read byte 0", d0, 8'h3C);
    chk("R6 read byte 1", d1, 8'h00);
    chk("R6 read byte 2", d2, 8'h22 ^ 8'hA5);
    chk("R6 released after host nack", sdaDriveLow, 0);
    // pointer did not advance on the refused byte
    busStart();
    sendByte({DEVA, 1'b1}, a0);
    recvByte(d0, 1'b0);
    busStop();
    chk("R6 no advance on nack", d0, 8'h22 ^ 8'hA5);
  endtask

  task automatic tReadOnly();
    logic a0, a1, a2;
    logic [7:0] d0;
    int w0 = wrCount;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h05, a1);
    sendByte(8'hFF, a2);
    busStop();
    chk("R5 data nack", a2, 0);
    chk("R5 location unchanged", mem[8'h05], 8'h05 ^ 8'hA5);
    chk("R5 no strobe", wrCount - w0, 0);
    busStart();
    sendByte({DEVA, 1'b1}, a0);
    recvByte(d0, 1'b0);
    busStop();
    chk("R5 pointer held", d0, 8'h05 ^ 8'hA5);
  endtask

  task automatic tCmdLimit();
    logic a0, a1;
    logic [7:0] d0;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h6B, a1);
    busStop();
    chk("R2 top command ack", a1, 1);
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h6C, a1);
    busStop();
    chk("R3 over-range nack", a1, 0);
    chk("R3 pointer kept", regAddr, 8'h6B);
    busStart();
    sendByte({DEVA, 1'b1}, a0);
    recvByte(d0, 1'b0);
    busStop();
    chk("R3 read at kept pointer", d0, 8'h6B ^ 8'hA5);
  endtask

  task automatic tMismatch();
    logic a0, a1, a2;
    int w0 = wrCount;
    int d0 = drvCount;
    busStart();
    sendByte({7'h12, 1'b0}, a0);
    sendByte(8'h40, a1);
    sendByte(8'h77, a2);
    busStop();
    chk("R7 no ack", {a0, a1, a2}, 3'b000);
    chk("R7 never drove", drvCount - d0, 0);
    chk("R7 no write", wrCount - w0, 0);
    chk("R7 location unchanged", mem[8'h40], 8'h40 ^ 8'hA5);
  endtask

  task automatic tAbort();
    logic a0, a1, s;
    logic [7:0] d0;
    int w0 = wrCount;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h30, a1);
    bitCell(1'b0, s);
    bitCell(1'b1, s);
    bitCell(1'b0, s);
    bitCell(1'b0, s);
    busStart();
    sendByte({DEVA, 1'b1}, a0);
    recvByte(d0, 1'b0);
    busStop();
    chk("R8 no write after abort", wrCount - w0, 0);
    chk("R8 read at kept pointer", d0, 8'h30 ^ 8'hA5);
  endtask

  task automatic tStuckExternal();
    logic s;
    int s0;
    busStart();
    for (int i = 6; i >= 0; i--) bitCell(DEVA[i], s);
    bitCell(1'b0, s);
    mSdaLow = 1'b0;
    extSclLow = 1'b1;
    waitC(Q);
    chk("R1 ack drive while scl held", sdaDriveLow, 1);
    waitC(STUCK + SETTLE + 50);
    chk("R9 released", {sdaDriveLow, sclDriveLow}, 2'b00);
    chk("R10 sleep request", sleepReq, 1);
    extSclLow = 1'b0;
    mSclLow = 1'b0;
    waitC(10);
    chk("R10 sleep cleared", sleepReq, 0);
    s0 = sleepCount;
    waitC(4 * Q);
    chk("R10 sleep stays low", sleepCount - s0, 0);
  endtask

  task automatic tStuckSelf();
    logic a0, a1, a2;
    logic [7:0] d0;
    int s0;
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h21, a1);
    busStart();
    sendByte({DEVA, 1'b1}, a2);
    mSdaLow = 1'b0;
    waitC(Q);
    chk("R6 msb zero driven", sdaDriveLow, 1);
    s0 = sleepCount;
    mSclLow = 1'b0;
    waitC(STUCK + SETTLE + 50);
    chk("R9 self release", sdaDriveLow, 0);
    chk("R10 no sleep when bus frees", sleepCount - s0, 0);
    busStart();
    sendByte({DEVA, 1'b0}, a0);
    sendByte(8'h20, a1);
    busStart();
    sendByte({DEVA, 1'b1}, a2);
    recvByte(d0, 1'b0);
    busStop();
    chk("R9 bus usable again", d0, 8'h3C);
  endtask

  initial begin
    waitC(5);
    rstN = 1'b1;
    waitC(5);
    tReset();
    tWriteRun();
    tReadRun();
    tReadOnly();
    tCmdLimit();
    tMismatch();
    tAbort();
    tStuckExternal();
    tStuckSelf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule